// File: doc/BRIEF.md
# Receive Reset Sequencer for a Serial Transceiver

This block steps a serial transceiver receiver through its reset when the elastic receive buffer is in use. It first holds the analog-side (PMA) reset, then waits for the receiver to report lock and for the user clocks to be stable. It then pulses the digital-side (PCS) reset and waits once more before it declares the receive link ready. A loss of lock in any later state sends it back to the PMA reset.

When the receive error input rises while lock is present, the sequencer retries with a PCS reset only. A retry counter bounds these attempts. Once the counter reaches its limit, the next error forces a full PMA reset, and the counter is cleared whenever the sequencer goes back to that state.

The block runs on a free-running system clock, because the receive user clock may be absent during reset. Every wait interval is set in user-clock periods and is multiplied by a prescale ratio, which is the number of system clocks per period of the slower user clock. The error input is expected to be the OR of the buffer overflow/underflow flag and a burst of disparity or not-in-table errors.

Top module: `rx_reset_seq`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the cycle after it is sampled, `pma_rst_o` is 1, `pcs_rst_o` is 0 and `ready_o` is 0. The retry counter is cleared.
- R2: With `clk_stable_i` high, `pma_rst_o` stays high for exactly PMA_CYC×PRESCALE system cycles after reset is released.
- R3: `pma_rst_o` does not fall while `clk_stable_i` is low. It falls only after `clk_stable_i` has been seen high.
- R4: After the PMA reset, the block waits with all three outputs low until `lock_i` and `clk_stable_i` are both high. The cycle after that, `pcs_rst_o` rises.
- R5: `pcs_rst_o` stays high for exactly PCS_CYC×PRESCALE cycles. It is only ever entered while `lock_i` is high.
- R6: After the PCS reset, all outputs stay low for WAIT_CYC×PRESCALE cycles. Then `ready_o` rises.
- R7: If `lock_i` is low while `pcs_rst_o` or `ready_o` is high, or during the post-PCS wait, `pma_rst_o` is 1 in the next cycle.
- R8: At most one of `pma_rst_o`, `pcs_rst_o` and `ready_o` is high in any cycle.
- R9: If `rx_err_i` and `lock_i` are both high in the ready or post-PCS-wait state, the block behaves as follows:
  - It goes to the PCS reset and increments the retry counter when the counter is below RETRY_MAX.
  - Otherwise it goes to the PMA reset.
- R10: The retry counter is cleared on every entry to the PMA reset. After an escalation, a full set of RETRY_MAX PCS retries is available again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Receiver lock indication |
| clk_stable_i | input | 1 | Both receive user clocks are stable |
| rx_err_i | input | 1 | Receive buffer error or burst of code errors |
| pma_rst_o | output | 1 | PMA reset to the transceiver |
| pcs_rst_o | output | 1 | PCS reset to the transceiver |
| ready_o | output | 1 | Receive link is ready |

## Verification
A clean bring-up with lock and clock-stable held high measures the exact length of each reset and wait phase. This tells the prescaled counts apart from unscaled or off-by-one counts. Runs that hold clock-stable or lock low check that each gate stops progress on its own.

Repeated single-cycle error pulses in the ready state separate three cases:
- a PCS retry below the limit;
- an escalation at the limit;
- a retry that becomes available again once the PMA reset has cleared the counter.

A lock drop in the ready state checks the fall-back path. A reset asserted mid-run checks the forced return to the PMA reset.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

    typedef enum logic [2:0] {
        ST_PMA   = 3'd0,
        ST_WLOCK = 3'd1,
        ST_PCS   = 3'd2,
        ST_WPCS  = 3'd3,
        ST_READY = 3'd4
    } rxrst_state_e;

    typedef struct packed {
        logic pma_rst;
        logic pcs_rst;
        logic ready;
    } rxrst_out_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic rxrst_out_t decode_out(rxrst_state_e s);
        rxrst_out_t o;
        o.pma_rst = (s == ST_PMA);
        o.pcs_rst = (s == ST_PCS);
        o.ready   = (s == ST_READY);
        return o;
    endfunction

endpackage

// File: rtl/rxrst_timer.sv
module rxrst_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = (cnt_q >= limit - W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/rxrst_retry.sv
module rxrst_retry #(
    parameter int RETRY_MAX = 2,
    localparam int RW = $clog2(RETRY_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic below
);
    logic [RW-1:0] cnt_q;

    assign below = (cnt_q < RW'(RETRY_MAX));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && below) begin
            cnt_q <= cnt_q + RW'(1);
        end
    end
endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq
    import rxrst_pkg::*;
#(
    parameter int PRESCALE  = 3,
    parameter int PMA_CYC   = 4,
    parameter int PCS_CYC   = 2,
    parameter int WAIT_CYC  = 5,
    parameter int RETRY_MAX = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic clk_stable_i,
    input  logic rx_err_i,
    output logic pma_rst_o,
    output logic pcs_rst_o,
    output logic ready_o
);
    localparam int PMA_LIM  = PMA_CYC * PRESCALE;
    localparam int PCS_LIM  = PCS_CYC * PRESCALE;
    localparam int WAIT_LIM = WAIT_CYC * PRESCALE;
    localparam int TW = $clog2(max3(PMA_LIM, PCS_LIM, WAIT_LIM) + 1);

    rxrst_state_e state_q, state_d;
    rxrst_out_t   outs;
    logic [TW-1:0] limit;
    logic          tmr_done;
    logic          retry_ok;
    logic          err_hit;
    logic          retry_inc;
    logic          retry_clr;

    always_comb begin
        case (state_q)
            ST_PMA:  limit = TW'(PMA_LIM);
            ST_PCS:  limit = TW'(PCS_LIM);
            ST_WPCS: limit = TW'(WAIT_LIM);
            default: limit = TW'(1);
        endcase
    end

    rxrst_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (state_d != state_q),
        .limit (limit),
        .done  (tmr_done)
    );

    assign err_hit   = rx_err_i && lock_i &&
                       (state_q == ST_WPCS || state_q == ST_READY);
    assign retry_inc = err_hit && retry_ok;
    assign retry_clr = (state_d == ST_PMA) && (state_q != ST_PMA);

    rxrst_retry #(.RETRY_MAX(RETRY_MAX)) u_retry (
        .clk   (clk),
        .rst   (rst),
        .clr   (retry_clr),
        .inc   (retry_inc),
        .below (retry_ok)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_PMA:   if (tmr_done && clk_stable_i) state_d = ST_WLOCK;
            ST_WLOCK: if (lock_i && clk_stable_i)   state_d = ST_PCS;
            ST_PCS: begin
                if (!lock_i)       state_d = ST_PMA;
                else if (tmr_done) state_d = ST_WPCS;
            end
            ST_WPCS: begin
                if (!lock_i)       state_d = ST_PMA;
                else if (err_hit)  state_d = retry_ok ? ST_PCS : ST_PMA;
                else if (tmr_done) state_d = ST_READY;
            end
            ST_READY: begin
                if (!lock_i)      state_d = ST_PMA;
                else if (err_hit) state_d = retry_ok ? ST_PCS : ST_PMA;
            end
            default: state_d = ST_PMA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PMA;
        else     state_q <= state_d;
    end

    assign outs      = decode_out(state_q);
    assign pma_rst_o = outs.pma_rst;
    assign pcs_rst_o = outs.pcs_rst;
    assign ready_o   = outs.ready;
endmodule

// File: rtl/rx_reset_seq_chk.sv
module rx_reset_seq_chk (
    input logic clk,
    input logic rst,
    input logic lock_i,
    input logic clk_stable_i,
    input logic pma_rst_o,
    input logic pcs_rst_o,
    input logic ready_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pma_rst_o && !pcs_rst_o && !ready_o));

    assert_stable_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pma_rst_o) |-> $past(clk_stable_i));

    assert_pcs_entry_lock_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pcs_rst_o) |-> $past(lock_i));

    assert_ready_entry_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(!pma_rst_o && !pcs_rst_o));

    assert_lock_loss_R7: assert property (@(posedge clk) disable iff (rst)
        (!lock_i && (pcs_rst_o || ready_o)) |=> pma_rst_o);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pma_rst_o, pcs_rst_o, ready_o}));
endmodule

bind rx_reset_seq rx_reset_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .lock_i       (lock_i),
    .clk_stable_i (clk_stable_i),
    .pma_rst_o    (pma_rst_o),
    .pcs_rst_o    (pcs_rst_o),
    .ready_o      (ready_o)
);

// File: tb/rx_reset_seq_bench.sv
`timescale 1ns/1ps
module rx_reset_seq_bench;
    localparam int PRESCALE  = 3;
    localparam int PMA_CYC   = 4;
    localparam int PCS_CYC   = 2;
    localparam int WAIT_CYC  = 5;
    localparam int RETRY_MAX = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_i = 1'b0;
    logic clk_stable_i = 1'b0;
    logic rx_err_i = 1'b0;
    logic pma_rst_o, pcs_rst_o, ready_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rx_reset_seq #(
        .PRESCALE(PRESCALE), .PMA_CYC(PMA_CYC), .PCS_CYC(PCS_CYC),
        .WAIT_CYC(WAIT_CYC), .RETRY_MAX(RETRY_MAX)
    ) u_rx_reset_seq (
        .clk(clk), .rst(rst), .lock_i(lock_i), .clk_stable_i(clk_stable_i),
        .rx_err_i(rx_err_i), .pma_rst_o(pma_rst_o), .pcs_rst_o(pcs_rst_o),
        .ready_o(ready_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_err_i = 1'b0;
        tick();
        tick();
        @(negedge clk);
        rst = 1'b0;
    endtask

    // count cycles until the given output goes low
    task automatic count_high(input int which, output int n);
        n = 0;
        while (((which == 0) ? pma_rst_o : pcs_rst_o) && n < 1000) begin
            tick();
            n++;
        end
    endtask

    task automatic count_to_ready(output int n);
        n = 0;
        while (!ready_o && n < 1000) begin
            tick();
            n++;
        end
    endtask

    task automatic pulse_err();
        @(negedge clk);
        rx_err_i = 1'b1;
        tick();
        @(negedge clk);
        rx_err_i = 1'b0;
    endtask

    task automatic t_reset_state();
        lock_i = 1'b1; clk_stable_i = 1'b1;
        do_reset();
        check(pma_rst_o && !pcs_rst_o && !ready_o, "R1 reset outputs",
              {pma_rst_o, pcs_rst_o, ready_o}, 3'b100);
    endtask

    task automatic t_bringup();
        int n;
        lock_i = 1'b1; clk_stable_i = 1'b1;
        do_reset();
        count_high(0, n);
        check(n == PMA_CYC*PRESCALE, "R2 pma width", n, PMA_CYC*PRESCALE);
        tick();
        check(pcs_rst_o == 1'b1, "R4 pcs after lock", pcs_rst_o, 1);
        count_high(1, n);
        check(n == PCS_CYC*PRESCALE, "R5 pcs width", n, PCS_CYC*PRESCALE);
        count_to_ready(n);
        check(n == WAIT_CYC*PRESCALE, "R6 wait before ready", n, WAIT_CYC*PRESCALE);
    endtask

    task automatic t_stable_gate();
        lock_i = 1'b1; clk_stable_i = 1'b0;
        do_reset();
        repeat (30) tick();
        check(pma_rst_o == 1'b1, "R3 pma held without stable", pma_rst_o, 1);
        @(negedge clk);
        clk_stable_i = 1'b1;
        tick();
        check(pma_rst_o == 1'b0, "R3 pma released after stable", pma_rst_o, 0);
    endtask

    task automatic t_lock_wait();
        int n;
        lock_i = 1'b0; clk_stable_i = 1'b1;
        do_reset();
        count_high(0, n);
        repeat (20) tick();
        check(!pma_rst_o && !pcs_rst_o && !ready_o, "R4 idle while unlocked",
              {pma_rst_o, pcs_rst_o, ready_o}, 0);
        @(negedge clk);
        lock_i = 1'b1;
        tick();
        check(pcs_rst_o == 1'b1, "R4 pcs on lock", pcs_rst_o, 1);
    endtask

    task automatic bring_ready();
        int n;
        lock_i = 1'b1; clk_stable_i = 1'b1;
        do_reset();
        count_to_ready(n);
    endtask

    task automatic t_lock_loss();
        bring_ready();
        @(negedge clk);
        lock_i = 1'b0;
        tick();
        check(pma_rst_o == 1'b1, "R7 lock loss to pma", pma_rst_o, 1);
        check(ready_o == 1'b0, "R8 ready dropped", ready_o, 0);
        @(negedge clk);
        lock_i = 1'b1;
    endtask

    task automatic t_retry();
        int n;
        bring_ready();
        for (int i = 0; i < RETRY_MAX; i++) begin
            pulse_err();
            check(pcs_rst_o == 1'b1 && !pma_rst_o, "R9 retry via pcs", pcs_rst_o, 1);
            count_to_ready(n);
        end
        pulse_err();
        check(pma_rst_o == 1'b1, "R9 escalate to pma", pma_rst_o, 1);
        count_to_ready(n);
        check(ready_o == 1'b1, "R10 ready again", ready_o, 1);
        pulse_err();
        check(pcs_rst_o == 1'b1, "R10 counter cleared", pcs_rst_o, 1);
    endtask

    task automatic t_mid_reset();
        bring_ready();
        @(negedge clk);
        rst = 1'b1;
        tick();
        check(pma_rst_o && !ready_o, "R1 mid-run reset", {pma_rst_o, ready_o}, 2'b10);
        @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_bringup();
        t_stable_gate();
        t_lock_wait();
        t_lock_loss();
        t_retry();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule